// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. An external baud generator supplies a tick pulse at sixteen times the bit rate. The receiver passes the line through a synchronizer, validates each start bit at its midpoint, and then samples every following bit at its centre. The character format is chosen at run time: five to nine data bits, parity off, even or odd, and one or two stop bits.

A completed character is placed in a single holding register, where the host picks it up with a data-read strobe. Four error conditions are tracked in sticky flags: bad parity, a missing stop bit, a break (line held low for a whole character), and overrun (a character arrives while the previous one is still unread). The flags stay set until the host pulses a status-read strobe. The configuration inputs are expected to stay stable while a character is being received.

Top module: `srx_receiver`

## Requirements
- R1: After reset, rx_valid is 0 and all four error flags are 0. An idle line, held high, produces no character.
- R2: cfg_data_bits selects the data length as a plain count from 5 to 9. Values below 5 act as 5 and values above 9 act as 9. Bits arrive least significant first and appear right-aligned in rx_data, with the unused upper bits at 0.
- R3: Bits are taken at 16 ticks per bit. A low level is accepted as a start bit only if the line is still low 8 ticks later, at mid-start-bit. A shorter low pulse is dropped and delivers nothing.
- R4: cfg_parity selects the parity check: 0 or 3 means no parity bit, 1 means even (data ones plus the parity bit give an even count), 2 means odd. On a mismatch, err_parity is set and the character is still delivered.
- R5: cfg_two_stop = 0 expects one stop bit and 1 expects two. err_frame is set when any expected stop-bit sample is low. The character is still delivered.
- R6: When every data sample, the parity sample (if enabled) and the first stop sample are all low, err_break and err_frame are both set and no character is delivered. The receiver then waits for the line to go high before it accepts a new start bit.
- R7: If a character completes while rx_valid is 1 and no data read is pulsed in that cycle, err_overrun is set, the new character is discarded, and rx_data keeps the unread character.
- R8: A pulse on rd_data_strobe clears rx_valid on the next cycle. It does not touch the error flags.
- R9: Error flags are sticky. A pulse on rd_status_strobe clears all four flags on the next cycle, unless a new error is raised in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Serial input line, idles high |
| cfg_data_bits | input | 4 | Data bit count (5..9) |
| cfg_parity | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_data_strobe | input | 1 | Host read of the holding register |
| rd_status_strobe | input | 1 | Host read of the status flags |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | Holding register contains an unread character |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_break | output | 1 | Sticky break detected |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The line passes through two synchronizer flops before the frame engine sees it. A character is therefore settled at the outputs within about five clocks of the tick that samples its final stop bit: two for the synchronizer, one for the frame engine's completion register, one for the holding register, plus margin. The bench does not sample near that edge. It checks data and flags two full bit times after the line has finished the last stop bit. The strobes act on the next clock, and their effects are read two clocks after the strobe is dropped. Every check is taken at a falling clock edge, so no result depends on the order of events at the active edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_BRKWAIT
  } srx_state_e;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF3 = 2'd3
  } srx_par_e;

  // per-character error result
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } srx_err_t;

  // sticky status flags
  typedef struct packed {
    logic ovr;
    logic brk;
    logic frm;
    logic par;
  } srx_flags_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  localparam int CW      = $clog2(OSR),
  localparam int IW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic [IW-1:0]       cfg_bits_i,
  input  logic [1:0]          cfg_par_i,
  input  logic                cfg_two_stop_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output srx_err_t            err_o
);

  localparam logic [CW-1:0] HALF_C = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
  localparam logic [IW-1:0] MINB_C = IW'(MIN_BITS);
  localparam logic [IW-1:0] MAXB_C = IW'(MAX_BITS);

  srx_state_e          state_q, state_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic                pacc_q, pacc_d;
  logic                zero_q, zero_d;
  logic                perr_q, perr_d;
  logic                ferr_q, ferr_d;
  logic                done_q, done_d;
  logic [MAX_BITS-1:0] data_q, data_d;
  srx_err_t            err_q, err_d;

  logic [IW-1:0]       nbits;
  logic                par_on;
  logic                par_odd;
  logic                mid_hit;
  logic                full_hit;
  logic [MAX_BITS-1:0] aligned;

  // configuration decode
  always_comb begin
    if (cfg_bits_i < MINB_C)      nbits = MINB_C;
    else if (cfg_bits_i > MAXB_C) nbits = MAXB_C;
    else                          nbits = cfg_bits_i;
    par_on  = (cfg_par_i == PAR_EVEN) || (cfg_par_i == PAR_ODD);
    par_odd = (cfg_par_i == PAR_ODD);
  end

  assign mid_hit  = tick_i && (cnt_q == HALF_C);
  assign full_hit = tick_i && (cnt_q == LAST_C);
  assign aligned  = sh_q >> (MAXB_C - nbits);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pacc_d  = pacc_q;
    zero_d  = zero_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    data_d  = data_q;
    err_d   = err_q;

    if (tick_i && (state_q != ST_IDLE) && (state_q != ST_BRKWAIT)) begin
      cnt_d = full_hit ? '0 : cnt_q + 1'b1;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (tick_i && !rx_i) begin
          state_d = ST_START;
          cnt_d   = '0;
          idx_d   = '0;
          pacc_d  = 1'b0;
          zero_d  = 1'b1;
          perr_d  = 1'b0;
          ferr_d  = 1'b0;
        end
      end
      ST_START: begin
        if (mid_hit) begin
          cnt_d   = '0;
          state_d = rx_i ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (full_hit) begin
          sh_d   = {rx_i, sh_q[MAX_BITS-1:1]};
          pacc_d = pacc_q ^ rx_i;
          zero_d = zero_q & ~rx_i;
          if (idx_q == nbits - 1'b1) begin
            idx_d   = '0;
            state_d = par_on ? ST_PAR : ST_STOP1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (full_hit) begin
          perr_d  = pacc_q ^ rx_i ^ par_odd;
          zero_d  = zero_q & ~rx_i;
          state_d = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (full_hit) begin
          if (!rx_i && zero_q) begin
            done_d    = 1'b1;
            data_d    = '0;
            err_d.brk = 1'b1;
            err_d.frm = 1'b1;
            err_d.par = 1'b0;
            state_d   = ST_BRKWAIT;
          end else if (cfg_two_stop_i) begin
            ferr_d  = ~rx_i;
            state_d = ST_STOP2;
          end else begin
            done_d    = 1'b1;
            data_d    = aligned;
            err_d.brk = 1'b0;
            err_d.frm = ~rx_i;
            err_d.par = perr_q;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_STOP2: begin
        if (full_hit) begin
          done_d    = 1'b1;
          data_d    = aligned;
          err_d.brk = 1'b0;
          err_d.frm = ferr_q | ~rx_i;
          err_d.par = perr_q;
          state_d   = ST_IDLE;
        end
      end
      ST_BRKWAIT: begin
        if (rx_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pacc_q  <= 1'b0;
      zero_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pacc_q  <= pacc_d;
      zero_q  <= zero_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      done_q  <= done_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign err_o  = err_q;

endmodule

// File: rtl/srx_holdreg.sv
module srx_holdreg
  import srx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  srx_err_t      err_i,
  input  logic          rd_data_i,
  input  logic          rd_stat_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output srx_flags_t    flags_o
);

  logic          valid_q, valid_d;
  logic [DW-1:0] data_q, data_d;
  srx_flags_t    flags_q, flags_d;
  srx_flags_t    set_v;
  logic          is_char;
  logic          load_en;
  logic          ovr_hit;

  assign is_char = done_i && !err_i.brk;
  assign load_en = is_char && (!valid_q || rd_data_i);
  assign ovr_hit = is_char && valid_q && !rd_data_i;

  always_comb begin
    set_v.ovr = ovr_hit;
    set_v.brk = done_i && err_i.brk;
    set_v.frm = done_i && err_i.frm;
    set_v.par = done_i && err_i.par;

    if (load_en)        valid_d = 1'b1;
    else if (rd_data_i) valid_d = 1'b0;
    else                valid_d = valid_q;

    data_d  = load_en ? data_i : data_q;
    flags_d = (rd_stat_i ? srx_flags_t'('0) : flags_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      flags_q <= flags_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_line,
  input  logic [IW-1:0]       cfg_data_bits,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                rd_data_strobe,
  input  logic                rd_status_strobe,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_break,
  output logic                err_overrun
);

  logic                rst_int_n;
  logic                rx_s;
  logic                frm_done;
  logic [MAX_BITS-1:0] frm_data;
  srx_err_t            frm_err;
  srx_flags_t          flags;

  // reset: asynchronous assertion, synchronous release
  srx_sync #(.STAGES(2), .RESET_VAL(1'b0)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) line_sync_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (rx_line),
    .q_o   (rx_s)
  );

  srx_framer #(.OSR(OSR), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) framer_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .tick_i         (os_tick),
    .rx_i           (rx_s),
    .cfg_bits_i     (cfg_data_bits),
    .cfg_par_i      (cfg_parity),
    .cfg_two_stop_i (cfg_two_stop),
    .done_o         (frm_done),
    .data_o         (frm_data),
    .err_o          (frm_err)
  );

  srx_holdreg #(.DW(MAX_BITS)) hold_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .done_i    (frm_done),
    .data_i    (frm_data),
    .err_i     (frm_err),
    .rd_data_i (rd_data_strobe),
    .rd_stat_i (rd_status_strobe),
    .valid_o   (rx_valid),
    .data_o    (rx_data),
    .flags_o   (flags)
  );

  assign err_frame   = flags.frm;
  assign err_parity  = flags.par;
  assign err_break   = flags.brk;
  assign err_overrun = flags.ovr;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rd_data_strobe,
  input logic          rd_status_strobe,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_break,
  input logic          err_overrun,
  input logic          frm_done
);

  // R9
  sticky_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !rd_status_strobe) |=> err_parity);

  // R9
  sticky_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !rd_status_strobe) |=> err_overrun);

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_strobe && !frm_done) |=>
      (!err_parity && !err_frame && !err_break && !err_overrun));

  // R7
  unread_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_data_strobe) |=> ($stable(rx_data) && rx_valid));

  // R6
  break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> err_frame);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rd_data_strobe));

endmodule

bind srx_receiver srx_checker #(.DW(MAX_BITS)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .rx_valid         (rx_valid),
  .rx_data          (rx_data),
  .rd_data_strobe   (rd_data_strobe),
  .rd_status_strobe (rd_status_strobe),
  .err_frame        (err_frame),
  .err_parity       (err_parity),
  .err_break        (err_break),
  .err_overrun      (err_overrun),
  .frm_done         (frm_done)
);

// File: tb/srx_receiver_tb_top.sv
`timescale 1ns/1ps
module srx_receiver_tb_top;

  localparam int TICKDIV = 4;
  localparam int BITCLK  = 16 * TICKDIV;
  localparam int WD_CYC  = 190000;

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       rx_line;
  logic [3:0] cfg_data_bits;
  logic [1:0] cfg_parity;
  logic       cfg_two_stop;
  logic       rd_data_strobe;
  logic       rd_status_strobe;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       err_frame;
  logic       err_parity;
  logic       err_break;
  logic       err_overrun;
  logic [1:0] tdiv;

  int vectors;
  int miscomp;

  srx_receiver dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .os_tick          (os_tick),
    .rx_line          (rx_line),
    .cfg_data_bits    (cfg_data_bits),
    .cfg_parity       (cfg_parity),
    .cfg_two_stop     (cfg_two_stop),
    .rd_data_strobe   (rd_data_strobe),
    .rd_status_strobe (rd_status_strobe),
    .rx_data          (rx_data),
    .rx_valid         (rx_valid),
    .err_frame        (err_frame),
    .err_parity       (err_parity),
    .err_break        (err_break),
    .err_overrun      (err_overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 1'b1;
  end
  assign os_tick = rst_n && (tdiv == 2'd3);

  function automatic int eff_bits(int n);
    if (n < 5) return 5;
    if (n > 9) return 9;
    return n;
  endfunction

  function automatic logic [8:0] mask_data(logic [8:0] d, int n);
    return d & 9'((1 << n) - 1);
  endfunction

  function automatic logic par_bit(logic [8:0] d, int n, int pm);
    logic p;
    p = ^mask_data(d, n);
    return (pm == 2) ? ~p : p;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(logic b, int clocks);
    rx_line = b;
    repeat (clocks) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(int n, int pm, bit two, logic [8:0] d,
                            bit flip, bit s1, bit s2);
    int en;
    en = eff_bits(n);
    drive_bit(1'b0, BITCLK);
    for (int i = 0; i < en; i++) drive_bit(d[i], BITCLK);
    if (pm == 1 || pm == 2) drive_bit(par_bit(d, en, pm) ^ flip, BITCLK);
    drive_bit(s1, BITCLK);
    if (two) drive_bit(s2, BITCLK);
    drive_bit(1'b1, 2 * BITCLK);
  endtask

  task automatic set_cfg(int n, int pm, bit two);
    cfg_data_bits = 4'(n);
    cfg_parity    = 2'(pm);
    cfg_two_stop  = two;
  endtask

  task automatic pulse(bit dat, bit st);
    @(posedge clk); #1;
    rd_data_strobe   = dat;
    rd_status_strobe = st;
    @(posedge clk); #1;
    rd_data_strobe   = 1'b0;
    rd_status_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_char(string req, int n, logic [8:0] d, bit ep, bit ef);
    @(negedge clk);
    chk(req, "rx_valid", int'(rx_valid), 1);
    chk(req, "rx_data", int'(rx_data), int'(mask_data(d, eff_bits(n))));
    chk(req, "err_parity", int'(err_parity), int'(ep));
    chk(req, "err_frame", int'(err_frame), int'(ef));
    chk(req, "err_break", int'(err_break), 0);
    chk(req, "err_overrun", int'(err_overrun), 0);
    pulse(1'b1, 1'b1);
    chk(req, "rx_valid after read", int'(rx_valid), 0);
    chk(req, "flags after read",
        int'({err_frame, err_parity, err_break, err_overrun}), 0);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    vectors = 0;
    miscomp = 0;
    void'($urandom(32'h5eed_0ac3));
    rst_n = 1'b0;
    rx_line = 1'b1;
    rd_data_strobe = 1'b0;
    rd_status_strobe = 1'b0;
    set_cfg(8, 0, 1'b0);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4 * BITCLK) @(posedge clk);
    #1;

    // R1: reset state, idle line
    @(negedge clk);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "err_frame", int'(err_frame), 0);
    chk("R1", "err_parity", int'(err_parity), 0);
    chk("R1", "err_break", int'(err_break), 0);
    chk("R1", "err_overrun", int'(err_overrun), 0);

    // R2: lengths, LSB first, clamping
    set_cfg(5, 0, 1'b0); send_frame(5, 0, 1'b0, 9'h015, 0, 1, 1);
    check_char("R2", 5, 9'h015, 0, 0);
    set_cfg(8, 0, 1'b0); send_frame(8, 0, 1'b0, 9'h0C3, 0, 1, 1);
    check_char("R2", 8, 9'h0C3, 0, 0);
    set_cfg(12, 0, 1'b0); send_frame(12, 0, 1'b0, 9'h1A5, 0, 1, 1);
    check_char("R2", 12, 9'h1A5, 0, 0);
    set_cfg(3, 0, 1'b0); send_frame(3, 0, 1'b0, 9'h01E, 0, 1, 1);
    check_char("R2", 3, 9'h01E, 0, 0);

    // R3: short low pulse is not a start bit
    set_cfg(8, 0, 1'b0);
    drive_bit(1'b0, 3 * TICKDIV);
    drive_bit(1'b1, 3 * BITCLK);
    @(negedge clk);
    chk("R3", "rx_valid after glitch", int'(rx_valid), 0);
    chk("R3", "err_frame after glitch", int'(err_frame), 0);

    // R4: parity modes, good and bad
    set_cfg(9, 2, 1'b1); send_frame(9, 2, 1'b1, 9'h1A5, 0, 1, 1);
    check_char("R4", 9, 9'h1A5, 0, 0);
    set_cfg(7, 1, 1'b0); send_frame(7, 1, 1'b0, 9'h05B, 1, 1, 1);
    check_char("R4", 7, 9'h05B, 1, 0);
    set_cfg(6, 2, 1'b0); send_frame(6, 2, 1'b0, 9'h021, 1, 1, 1);
    check_char("R4", 6, 9'h021, 1, 0);
    set_cfg(8, 3, 1'b0); send_frame(8, 3, 1'b0, 9'h07F, 0, 1, 1);
    check_char("R4", 8, 9'h07F, 0, 0);

    // R5: missing stop bits
    set_cfg(8, 0, 1'b0); send_frame(8, 0, 1'b0, 9'h081, 0, 0, 1);
    check_char("R5", 8, 9'h081, 0, 1);
    set_cfg(8, 1, 1'b1); send_frame(8, 1, 1'b1, 9'h03C, 0, 1, 0);
    check_char("R5", 8, 9'h03C, 0, 1);
    set_cfg(8, 1, 1'b1); send_frame(8, 1, 1'b1, 9'h03C, 0, 1, 1);
    check_char("R5", 8, 9'h03C, 0, 0);

    // R6: break, then wait for line high
    set_cfg(8, 1, 1'b0);
    drive_bit(1'b0, 14 * BITCLK);
    @(negedge clk);
    chk("R6", "err_break", int'(err_break), 1);
    chk("R6", "err_frame", int'(err_frame), 1);
    chk("R6", "err_parity", int'(err_parity), 0);
    chk("R6", "rx_valid", int'(rx_valid), 0);
    pulse(1'b0, 1'b1);
    drive_bit(1'b0, 2 * BITCLK);
    @(negedge clk);
    chk("R6", "no repeat break while low", int'(err_break), 0);
    drive_bit(1'b1, 2 * BITCLK);
    send_frame(8, 1, 1'b0, 9'h0A7, 0, 1, 1);
    check_char("R6", 8, 9'h0A7, 0, 0);

    // R7 / R8 / R9: overrun, data read, sticky status
    set_cfg(8, 0, 1'b0);
    send_frame(8, 0, 1'b0, 9'h011, 0, 1, 1);
    send_frame(8, 0, 1'b0, 9'h0EE, 0, 1, 1);
    @(negedge clk);
    chk("R7", "err_overrun", int'(err_overrun), 1);
    chk("R7", "rx_data kept", int'(rx_data), 'h11);
    chk("R7", "rx_valid", int'(rx_valid), 1);
    pulse(1'b1, 1'b0);
    chk("R8", "rx_valid after data read", int'(rx_valid), 0);
    chk("R9", "overrun still set", int'(err_overrun), 1);
    repeat (BITCLK) @(negedge clk);
    chk("R9", "overrun held", int'(err_overrun), 1);
    pulse(1'b0, 1'b1);
    chk("R9", "overrun cleared", int'(err_overrun), 0);

    // R2 / R4 / R5: random frames
    for (int k = 0; k < 30; k++) begin
      int n;
      int pm;
      bit two;
      bit flip;
      logic [8:0] d;
      n    = 5 + int'($urandom_range(4, 0));
      pm   = int'($urandom_range(3, 0));
      two  = 1'($urandom_range(1, 0));
      flip = ($urandom_range(3, 0) == 0);
      d    = 9'($urandom);
      set_cfg(n, pm, two);
      send_frame(n, pm, two, d, flip, 1, 1);
      check_char("R4", n, d, flip && (pm == 1 || pm == 2), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule